// File: doc/BRIEF.md
# Wave-Ordered Memory Request Sequencer

A dataflow fabric fires loads, stores and memory no-ops whenever their operands are ready, so they reach this block in no useful order. Each operation carries a wave number and three ordering links: the sequence number of the operation before it, its own sequence number, and the sequence number of the operation after it. Either neighbour link may hold the unknown code, used where a branch leaves the neighbour undetermined. The sequencer parks operations in a small slot buffer and releases them one at a time to a memory port, in the order that the links describe.

A memory no-op never touches memory. The compiler places one on each control path that has no real memory operation, so that the chain stays unbroken. The sequencer tracks the wave it expects next, the own number of the last released operation and that operation's successor link. When an operation marked as the end of its wave is released, the expected wave advances by one. Loads that complete return their data to the fabric, tagged with their wave and sequence number.

Both the request input and the memory port are valid/ready streams. An offer is held, with all fields stable, until the cycle in which ready is high. The input drops ready only when the buffer is full. The memory request holds until the memory accepts it. The load-return path has no ready: the fabric always takes it.

Top module: `wave_order_seq`

## Requirements
- R1: During and after reset, with nothing yet accepted, `in_ready` is 1 and both `mem_valid` and `ld_valid` are 0. The expected wave is 0. The last-issued sequence is 0 and the last successor is unknown.
- R2: A buffered operation of the expected wave becomes eligible when its predecessor field is not the unknown code and equals the last-issued sequence number. A wave's first operation names predecessor 0.
- R3: A buffered operation of the expected wave becomes eligible when the last issued operation's successor field is not unknown and equals its own sequence number. This holds even when its own predecessor field is unknown.
- R4: An operation that neither R2 nor R3 makes eligible stays buffered, and the memory port stays idle (`mem_valid` = 0) for as long as no other operation is eligible.
- R5: Memory requests leave in chain order, whatever order the operations arrived in. An eligible operation is shown on the port in the cycle after it is accepted, at the earliest.
- R6: An operation with kind 2'b10 (no-op) retires in the cycle it becomes eligible. It updates the last-issued state and makes no memory request.
- R7: When an operation with `in_wave_end` = 1 retires, the expected wave increments (modulo 2^WAVE_W). The last-issued sequence returns to 0 and the last successor to unknown. Operations of any other wave are held meanwhile.
- R8: The buffer holds DEPTH (16) operations. `in_ready` is 0 exactly while all DEPTH slots are occupied, and no offer is taken then.
- R9: A load accepted by the memory returns one cycle later on `ld_valid`. `ld_data` carries the memory read data, and `ld_wave`/`ld_seq` carry the load's wave and own sequence number.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, the request stays valid and its address, write flag and data stay unchanged.
- R11: Kind 2'b01 (store) presents `mem_we` = 1 with its address and data. Kind 2'b00 (load) presents `mem_we` = 0 with its address. The unknown link code is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | A buffer slot is free |
| in_kind | input | 2 | 00 load, 01 store, 10 no-op |
| in_wave | input | WAVE_W | Wave number |
| in_pred | input | SEQ_W | Predecessor sequence, all ones = unknown |
| in_seq | input | SEQ_W | Own sequence number |
| in_succ | input | SEQ_W | Successor sequence, all ones = unknown |
| in_wave_end | input | 1 | Last operation of its wave |
| in_addr | input | ADDR_W | Memory address |
| in_wdata | input | DATA_W | Store data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory takes the request |
| mem_we | output | 1 | 1 store, 0 load |
| mem_addr | output | ADDR_W | Request address |
| mem_wdata | output | DATA_W | Store data |
| mem_rvalid | input | 1 | Read data valid, one cycle after a load is taken |
| mem_rdata | input | DATA_W | Read data |
| ld_valid | output | 1 | Load result to the fabric |
| ld_wave | output | WAVE_W | Wave of the returning load |
| ld_seq | output | SEQ_W | Sequence number of the returning load |
| ld_data | output | DATA_W | Load result |

## Verification
The assertions assume well-formed chains. Sequence numbers are unique within a wave. Of any two neighbours, at least one carries a known link to the other, so at most one buffered operation is ever eligible. They also assume that the memory raises `mem_rvalid` exactly one cycle after it takes a load, and at no other time. The stimulus builds each wave from increasing sequence numbers. It makes a predecessor unknown only where the previous operation's successor link is filled in. It never puts more than two consecutive waves in flight, with at most 16 operations between them, and the bench memory model answers loads on the following cycle.

// File: rtl/wos_pkg.sv
package wos_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_NOP   = 2'b10
  } op_kind_e;
endpackage

// File: rtl/wos_buffer.sv
// Slot storage for pending operations: lowest free slot is filled,
// any slot can be released by index.
module wos_buffer #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 6,
  parameter int WAVE_W = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [WAVE_W-1:0] wr_wave,
  input  logic [SEQ_W-1:0]  wr_pred,
  input  logic [SEQ_W-1:0]  wr_seq,
  input  logic [SEQ_W-1:0]  wr_succ,
  input  logic              wr_last,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rel_en,
  input  logic [IDX_W-1:0]  rel_idx,
  output logic              full,
  output logic [DEPTH-1:0]  vld,
  output logic [1:0]        kind_q [DEPTH],
  output logic [WAVE_W-1:0] wave_q [DEPTH],
  output logic [SEQ_W-1:0]  pred_q [DEPTH],
  output logic [SEQ_W-1:0]  seq_q  [DEPTH],
  output logic [SEQ_W-1:0]  succ_q [DEPTH],
  output logic              last_q [DEPTH],
  output logic [ADDR_W-1:0] addr_q [DEPTH],
  output logic [DATA_W-1:0] data_q [DEPTH]
);
  logic [IDX_W-1:0] free_idx;
  logic             free_ok;

  always_comb begin
    free_idx = '0;
    free_ok  = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_idx = IDX_W'(i);
        free_ok  = 1'b1;
      end
    end
  end

  assign full = !free_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && free_ok && free_idx == IDX_W'(i))
          vld[i] <= 1'b1;
        else if (rel_en && rel_idx == IDX_W'(i))
          vld[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && free_ok && free_idx == IDX_W'(i)) begin
        kind_q[i] <= wr_kind;
        wave_q[i] <= wr_wave;
        pred_q[i] <= wr_pred;
        seq_q[i]  <= wr_seq;
        succ_q[i] <= wr_succ;
        last_q[i] <= wr_last;
        addr_q[i] <= wr_addr;
        data_q[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/wos_match.sv
// Per-slot link comparison and lowest-index pick of the eligible slot.
module wos_match #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 6,
  parameter int WAVE_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]  vld,
  input  logic [WAVE_W-1:0] wave_q [DEPTH],
  input  logic [SEQ_W-1:0]  pred_q [DEPTH],
  input  logic [SEQ_W-1:0]  seq_q  [DEPTH],
  input  logic [WAVE_W-1:0] cur_wave,
  input  logic [SEQ_W-1:0]  last_seq,
  input  logic [SEQ_W-1:0]  last_succ,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  localparam logic [SEQ_W-1:0] UNK = '1;

  logic [DEPTH-1:0] elig;
  logic             succ_known;

  assign succ_known = (last_succ != UNK);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic by_pred;
    logic by_succ;
    assign by_pred = (pred_q[g] != UNK) && (pred_q[g] == last_seq);
    assign by_succ = succ_known && (seq_q[g] == last_succ);
    assign elig[g] = vld[g] && (wave_q[g] == cur_wave) && (by_pred || by_succ);
  end

  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wos_track.sv
// Expected wave and the link state of the last released operation.
module wos_track #(
  parameter int SEQ_W  = 6,
  parameter int WAVE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic [SEQ_W-1:0]  adv_seq,
  input  logic [SEQ_W-1:0]  adv_succ,
  input  logic              adv_end,
  output logic [WAVE_W-1:0] cur_wave,
  output logic [SEQ_W-1:0]  last_seq,
  output logic [SEQ_W-1:0]  last_succ
);
  localparam logic [SEQ_W-1:0] UNK   = '1;
  localparam logic [SEQ_W-1:0] START = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_wave  <= '0;
      last_seq  <= START;
      last_succ <= UNK;
    end else if (adv) begin
      if (adv_end) begin
        cur_wave  <= cur_wave + WAVE_W'(1);
        last_seq  <= START;
        last_succ <= UNK;
      end else begin
        last_seq  <= adv_seq;
        last_succ <= adv_succ;
      end
    end
  end
endmodule

// File: rtl/wos_ldtag.sv
// Holds the wave/sequence tag of the load in flight at the memory.
module wos_ldtag #(
  parameter int SEQ_W  = 6,
  parameter int WAVE_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [WAVE_W-1:0] cap_wave,
  input  logic [SEQ_W-1:0]  cap_seq,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  output logic              ld_valid,
  output logic [WAVE_W-1:0] ld_wave,
  output logic [SEQ_W-1:0]  ld_seq,
  output logic [DATA_W-1:0] ld_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_wave <= '0;
      ld_seq  <= '0;
    end else if (cap) begin
      ld_wave <= cap_wave;
      ld_seq  <= cap_seq;
    end
  end

  assign ld_valid = rvalid;
  assign ld_data  = rdata;
endmodule

// File: rtl/wave_order_seq.sv
module wave_order_seq #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 6,
  parameter int WAVE_W = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic [WAVE_W-1:0] in_wave,
  input  logic [SEQ_W-1:0]  in_pred,
  input  logic [SEQ_W-1:0]  in_seq,
  input  logic [SEQ_W-1:0]  in_succ,
  input  logic              in_wave_end,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ld_valid,
  output logic [WAVE_W-1:0] ld_wave,
  output logic [SEQ_W-1:0]  ld_seq,
  output logic [DATA_W-1:0] ld_data
);
  import wos_pkg::*;

  localparam int IDX_W = $clog2(DEPTH);

  logic              full;
  logic [DEPTH-1:0]  vld;
  logic [1:0]        kind_q [DEPTH];
  logic [WAVE_W-1:0] wave_q [DEPTH];
  logic [SEQ_W-1:0]  pred_q [DEPTH];
  logic [SEQ_W-1:0]  seq_q  [DEPTH];
  logic [SEQ_W-1:0]  succ_q [DEPTH];
  logic              last_q [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  logic              hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [WAVE_W-1:0] cur_wave;
  logic [SEQ_W-1:0]  last_seq;
  logic [SEQ_W-1:0]  last_succ;

  logic [1:0]        sel_kind;
  logic [SEQ_W-1:0]  sel_seq;
  logic [SEQ_W-1:0]  sel_succ;
  logic              sel_last;
  logic              sel_nop;
  logic              retire;
  logic              ld_take;

  assign in_ready = !full;

  wos_buffer #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .WAVE_W(WAVE_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (in_valid && in_ready),
    .wr_kind (in_kind),
    .wr_wave (in_wave),
    .wr_pred (in_pred),
    .wr_seq  (in_seq),
    .wr_succ (in_succ),
    .wr_last (in_wave_end),
    .wr_addr (in_addr),
    .wr_data (in_wdata),
    .rel_en  (retire),
    .rel_idx (hit_idx),
    .full    (full),
    .vld     (vld),
    .kind_q  (kind_q),
    .wave_q  (wave_q),
    .pred_q  (pred_q),
    .seq_q   (seq_q),
    .succ_q  (succ_q),
    .last_q  (last_q),
    .addr_q  (addr_q),
    .data_q  (data_q)
  );

  wos_match #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .WAVE_W(WAVE_W)
  ) u_match (
    .vld       (vld),
    .wave_q    (wave_q),
    .pred_q    (pred_q),
    .seq_q     (seq_q),
    .cur_wave  (cur_wave),
    .last_seq  (last_seq),
    .last_succ (last_succ),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  assign sel_kind = kind_q[hit_idx];
  assign sel_seq  = seq_q[hit_idx];
  assign sel_succ = succ_q[hit_idx];
  assign sel_last = last_q[hit_idx];
  assign sel_nop  = (sel_kind == OP_NOP);

  assign mem_valid = hit && !sel_nop;
  assign mem_we    = (sel_kind == OP_STORE);
  assign mem_addr  = addr_q[hit_idx];
  assign mem_wdata = data_q[hit_idx];

  assign retire  = hit && (sel_nop || mem_ready);
  assign ld_take = mem_valid && mem_ready && !mem_we;

  wos_track #(
    .SEQ_W(SEQ_W), .WAVE_W(WAVE_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (retire),
    .adv_seq   (sel_seq),
    .adv_succ  (sel_succ),
    .adv_end   (sel_last),
    .cur_wave  (cur_wave),
    .last_seq  (last_seq),
    .last_succ (last_succ)
  );

  wos_ldtag #(
    .SEQ_W(SEQ_W), .WAVE_W(WAVE_W), .DATA_W(DATA_W)
  ) u_ldtag (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap      (ld_take),
    .cap_wave (cur_wave),
    .cap_seq  (sel_seq),
    .rvalid   (mem_rvalid),
    .rdata    (mem_rdata),
    .ld_valid (ld_valid),
    .ld_wave  (ld_wave),
    .ld_seq   (ld_seq),
    .ld_data  (ld_data)
  );
endmodule

// File: rtl/wos_checker.sv
module wos_checker #(
  parameter int DEPTH  = 16,
  parameter int SEQ_W  = 6,
  parameter int WAVE_W = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              ld_valid,
  input logic              retire,
  input logic              sel_last,
  input logic [SEQ_W-1:0]  sel_seq,
  input logic [WAVE_W-1:0] cur_wave,
  input logic [SEQ_W-1:0]  last_seq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      occ <= '0;
    else
      occ <= occ + CNT_W'(in_valid && in_ready) - CNT_W'(retire);
  end

  // R8
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  // R8
  ready_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (occ != CNT_W'(DEPTH)));

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

  // R7
  wave_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && sel_last) |=> (cur_wave == $past(cur_wave) + WAVE_W'(1)) &&
                             (last_seq == '0));

  // R5
  chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !sel_last) |=> (last_seq == $past(sel_seq)) && $stable(cur_wave));

  // R9
  load_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_we) |=> ld_valid);

  // R9
  return_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_valid && mem_ready && !mem_we));
endmodule

bind wave_order_seq wos_checker #(
  .DEPTH(DEPTH), .SEQ_W(SEQ_W), .WAVE_W(WAVE_W),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .ld_valid  (ld_valid),
  .retire    (retire),
  .sel_last  (sel_last),
  .sel_seq   (sel_seq),
  .cur_wave  (cur_wave),
  .last_seq  (last_seq)
);

// File: tb/wave_order_seq_tb.sv
module wave_order_seq_tb;
  localparam int DEPTH  = 16;
  localparam int SEQ_W  = 6;
  localparam int WAVE_W = 4;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [SEQ_W-1:0] UNK = '1;
  localparam logic [1:0] K_LD = 2'b00, K_ST = 2'b01, K_NOP = 2'b10;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [1:0]        in_kind;
  logic [WAVE_W-1:0] in_wave;
  logic [SEQ_W-1:0]  in_pred, in_seq, in_succ;
  logic              in_wave_end;
  logic [ADDR_W-1:0] in_addr;
  logic [DATA_W-1:0] in_wdata;
  logic              mem_valid, mem_ready, mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_wdata;
  logic              mem_rvalid = 1'b0;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic              ld_valid;
  logic [WAVE_W-1:0] ld_wave;
  logic [SEQ_W-1:0]  ld_seq;
  logic [DATA_W-1:0] ld_data;

  wave_order_seq #(
    .DEPTH(DEPTH), .SEQ_W(SEQ_W), .WAVE_W(WAVE_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
    .in_wave(in_wave), .in_pred(in_pred), .in_seq(in_seq), .in_succ(in_succ),
    .in_wave_end(in_wave_end), .in_addr(in_addr), .in_wdata(in_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .ld_valid(ld_valid), .ld_wave(ld_wave), .ld_seq(ld_seq), .ld_data(ld_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  int wv = 0;
  int hs_cnt = 0;
  int rdy_pct = 100;
  bit hold_rdy = 1'b0;

  logic [DATA_W-1:0] mem_arr [256];
  logic [DATA_W-1:0] ref_arr [256];
  logic              pend_ld = 1'b0;
  logic [DATA_W-1:0] pend_data = '0;

  // operations of the waves being sent, in chain order
  logic [1:0]        o_kind [32];
  logic [WAVE_W-1:0] o_wave [32];
  logic [SEQ_W-1:0]  o_pred [32], o_seq [32], o_succ [32];
  logic              o_end [32];
  logic [ADDR_W-1:0] o_addr [32];
  logic [DATA_W-1:0] o_data [32];
  bit                o_unk [32];
  int                ord [32];

  // expected memory requests and load returns
  logic              e_we [4096];
  logic [ADDR_W-1:0] e_addr [4096];
  logic [DATA_W-1:0] e_data [4096];
  logic [WAVE_W-1:0] e_wave [4096];
  logic [SEQ_W-1:0]  e_seq [4096];
  int exp_wr = 0, exp_rd = 0;
  logic [WAVE_W-1:0] q_wave [4096];
  logic [SEQ_W-1:0]  q_seq [4096];
  logic [DATA_W-1:0] q_data [4096];
  int lq_wr = 0, lq_rd = 0;

  task automatic chk(input string req, input logic [63:0] act,
                     input logic [63:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model: ready chosen at negedge, handshake observed 1 ns later
  always @(negedge clk) begin
    mem_ready = hold_rdy ? 1'b0 : ($urandom_range(99) < rdy_pct);
    #1;
    pend_ld = 1'b0;
    if (rst_n && mem_valid && mem_ready) begin
      hs_cnt++;
      if (exp_rd >= exp_wr) begin
        chk("R5", 64'(mem_addr), 64'hFFFF_FFFF, "unexpected request addr");
      end else begin
        chk("R5", 64'(mem_addr), 64'(e_addr[exp_rd]), "address in chain order");
        chk("R11", 64'(mem_we), 64'(e_we[exp_rd]), "write flag");
        if (mem_we) begin
          if (e_we[exp_rd]) chk("R11", 64'(mem_wdata), 64'(e_data[exp_rd]), "store data");
          mem_arr[mem_addr] = mem_wdata;
        end else begin
          pend_ld = 1'b1;
          pend_data = mem_arr[mem_addr];
          q_wave[lq_wr] = e_wave[exp_rd];
          q_seq[lq_wr]  = e_seq[exp_rd];
          q_data[lq_wr] = e_data[exp_rd];
          lq_wr++;
        end
        exp_rd++;
      end
    end
    if (rst_n && ld_valid) begin
      if (lq_rd >= lq_wr) begin
        chk("R9", 64'(ld_valid), 64'(0), "unexpected load return");
      end else begin
        chk("R9", 64'(ld_wave), 64'(q_wave[lq_rd]), "load wave tag");
        chk("R9", 64'(ld_seq), 64'(q_seq[lq_rd]), "load sequence tag");
        chk("R9", 64'(ld_data), 64'(q_data[lq_rd]), "load data");
        lq_rd++;
      end
    end
  end

  always @(posedge clk) begin
    mem_rvalid <= pend_ld;
    mem_rdata  <= pend_data;
  end

  // enter ops base..base+n-1 (chain order) into the expected queue
  task automatic plan_exp(input int base, input int n);
    for (int k = base; k < base + n; k++) begin
      if (o_kind[k] != K_NOP) begin
        e_we[exp_wr]   = (o_kind[k] == K_ST);
        e_addr[exp_wr] = o_addr[k];
        e_wave[exp_wr] = o_wave[k];
        e_seq[exp_wr]  = o_seq[k];
        if (o_kind[k] == K_ST) begin
          e_data[exp_wr] = o_data[k];
          ref_arr[o_addr[k]] = o_data[k];
        end else begin
          e_data[exp_wr] = ref_arr[o_addr[k]];
        end
        exp_wr++;
      end
    end
  endtask

  task automatic set_op(input int k, input logic [1:0] kind, input int w,
                        input logic [SEQ_W-1:0] p, input logic [SEQ_W-1:0] s,
                        input logic [SEQ_W-1:0] n, input logic e,
                        input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    o_kind[k] = kind; o_wave[k] = WAVE_W'(w); o_pred[k] = p; o_seq[k] = s;
    o_succ[k] = n; o_end[k] = e; o_addr[k] = a; o_data[k] = d;
  endtask

  // random well-formed wave of n ops at base, using the next wave number
  task automatic gen_wave(input int base, input int n);
    int s;
    s = 0;
    for (int i = 0; i < n; i++) begin
      s = s + 1 + int'($urandom_range(1));
      o_seq[base+i]  = SEQ_W'(s);
      o_unk[base+i]  = (i > 0) && ($urandom_range(2) == 0);
      o_wave[base+i] = WAVE_W'(wv);
      o_kind[base+i] = ($urandom_range(9) < 2) ? K_NOP :
                       ($urandom_range(1) == 1 ? K_ST : K_LD);
      o_addr[base+i] = ADDR_W'($urandom_range(7));
      o_data[base+i] = $urandom;
      o_end[base+i]  = (i == n - 1);
    end
    for (int i = 0; i < n; i++) begin
      o_pred[base+i] = (i == 0) ? '0 : (o_unk[base+i] ? UNK : o_seq[base+i-1]);
      if (i == n - 1)
        o_succ[base+i] = UNK;
      else if (o_unk[base+i+1] || $urandom_range(1) == 1)
        o_succ[base+i] = o_seq[base+i+1];
      else
        o_succ[base+i] = UNK;
    end
    plan_exp(base, n);
    wv++;
  endtask

  task automatic send(input int k);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_kind = o_kind[k]; in_wave = o_wave[k];
    in_pred = o_pred[k]; in_seq = o_seq[k]; in_succ = o_succ[k];
    in_wave_end = o_end[k]; in_addr = o_addr[k]; in_wdata = o_data[k];
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard;
    guard = 0;
    while ((exp_rd != exp_wr || lq_rd != lq_wr) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int h0, n1, n2, tot;
    bit idle;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin mem_arr[i] = '0; ref_arr[i] = '0; end
    rst_n = 1'b0; in_valid = 1'b0; in_kind = '0; in_wave = '0; in_pred = '0;
    in_seq = '0; in_succ = '0; in_wave_end = 1'b0; in_addr = '0; in_wdata = '0;
    repeat (3) @(negedge clk);
    chk("R1", 64'(in_ready), 64'(1), "in_ready in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 64'(in_ready), 64'(1), "in_ready after reset");
    chk("R1", 64'(mem_valid), 64'(0), "mem_valid after reset");
    chk("R1", 64'(ld_valid), 64'(0), "ld_valid after reset");

    // R4 / R3: unknown predecessor waits for its linking store
    set_op(0, K_ST, wv, '0, 6'd1, 6'd2, 1'b0, 8'd5, 32'hCAFE_0001);
    set_op(1, K_LD, wv, UNK, 6'd2, UNK, 1'b1, 8'd5, '0);
    plan_exp(0, 2); wv++;
    send(1);
    idle = 1'b1;
    repeat (6) begin @(negedge clk); if (mem_valid) idle = 1'b0; end
    chk("R4", 64'(idle), 64'(1), "port idle while link missing");
    send(0);
    drain();
    chk("R3", 64'(exp_rd), 64'(exp_wr), "successor-linked load issued");

    // R6: leading no-op makes no request
    h0 = hs_cnt;
    set_op(0, K_NOP, wv, '0, 6'd1, UNK, 1'b0, 8'd0, '0);
    set_op(1, K_ST, wv, 6'd1, 6'd3, UNK, 1'b1, 8'd6, 32'h0000_BEEF);
    plan_exp(0, 2); wv++;
    send(0); send(1);
    drain();
    chk("R6", 64'(hs_cnt - h0), 64'(1), "requests for no-op plus store");

    // R7: op of the next wave is held until the current wave ends
    set_op(1, K_ST, wv, '0, 6'd1, UNK, 1'b1, 8'd7, 32'h1111_2222);
    set_op(0, K_ST, wv + 1, '0, 6'd1, UNK, 1'b1, 8'd7, 32'h3333_4444);
    plan_exp(1, 1); plan_exp(0, 1); wv += 2;
    send(0);
    idle = 1'b1;
    repeat (4) begin @(negedge clk); if (mem_valid) idle = 1'b0; end
    chk("R7", 64'(idle), 64'(1), "later wave held");
    send(1);
    drain();
    chk("R7", 64'(exp_rd), 64'(exp_wr), "both waves issued in wave order");

    // R8 / R10: fill all slots while memory stalls
    hold_rdy = 1'b1;
    h0 = hs_cnt;
    for (int i = 0; i < 16; i++)
      set_op(i, K_ST, wv, (i == 0) ? '0 : SEQ_W'(i), SEQ_W'(i + 1),
             SEQ_W'(i + 2), (i == 15), ADDR_W'(16 + i), 32'(1000 + i));
    plan_exp(0, 16); wv++;
    for (int i = 0; i < 16; i++) send(i);
    @(negedge clk);
    chk("R8", 64'(in_ready), 64'(0), "in_ready with buffer full");
    chk("R10", 64'(mem_valid), 64'(1), "request held under stall");
    chk("R10", 64'(mem_addr), 64'(16), "held request address");
    in_valid = 1'b1; in_kind = K_ST; in_wave = WAVE_W'(wv); in_pred = '0;
    in_seq = 6'd1; in_succ = UNK; in_wave_end = 1'b1; in_addr = 8'd99;
    in_wdata = 32'hDEAD;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk("R10", 64'(mem_addr), 64'(16), "address stable after stall");
    hold_rdy = 1'b0;
    drain();
    repeat (10) @(negedge clk);
    chk("R8", 64'(hs_cnt - h0), 64'(16), "offer refused while full");

    // random mixed traffic: two consecutive waves shuffled together
    for (int r = 0; r < 40; r++) begin
      rdy_pct = 50 + int'($urandom_range(50));
      n1 = 2 + int'($urandom_range(6));
      n2 = 2 + int'($urandom_range(6));
      gen_wave(0, n1);
      gen_wave(n1, n2);
      tot = n1 + n2;
      for (int i = 0; i < tot; i++) ord[i] = i;
      for (int i = tot - 1; i > 0; i--) begin
        int j, t;
        j = int'($urandom_range(i));
        t = ord[i]; ord[i] = ord[j]; ord[j] = t;
      end
      for (int i = 0; i < tot; i++) send(ord[i]);
      drain();
    end
    rdy_pct = 100;
    repeat (10) @(negedge clk);
    chk("R5", 64'(exp_rd), 64'(exp_wr), "all requests issued");
    chk("R9", 64'(lq_rd), 64'(lq_wr), "all loads returned");
    chk("R2", 64'(in_ready), 64'(1), "buffer empty at end");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule